// File: doc/BRIEF.md
# Three-Wire Register Bus Controller

This block lets on-chip logic read and write the 16-bit registers of an external device that hangs on a three-wire bus. The bus has a serial clock, an active-low select and one shared data line. The host gives a one-cycle start pulse with a direction flag, a 7-bit register address and, for writes, a 16-bit value. When the transfer is over, the block answers with a one-cycle done pulse. For a read, the returned word is valid at the same moment.

The serial clock is made from the system clock. Each half period lasts `HALF_DIV` system cycles. The default of 2 at 50 MHz gives 40 ns high and 40 ns low, and every select and data change sits a full half period away from the edge that samples it. The shared line appears as separate output, output-enable and input pins, and the pad is placed outside the block.

Every transfer lasts 27 serial clock periods. Select drops on the first falling edge. Rising edge 2 is a dummy slot, rising edge 3 carries the direction, and rising edges 4 to 10 carry the address. A write then sends its word and lifts select, and one extra rising edge commits the word. A read releases the line and leaves a turnaround gap. It then samples the device's word on falling edges.

Top module: `tw_master`

## Requirements
- R1: After reset, and whenever no transfer is active, `bus_sel_n` is 1 and `bus_sd_oe`, `bus_sclk` and `done` are 0.
- R2: Each high and each low phase of `bus_sclk` lasts exactly `HALF_DIV` system clock cycles. Rising edge k falls (2k-1)·HALF_DIV cycles after the cycle in which the start is accepted.
- R3: `bus_sel_n` is still high at rising edge 1 and goes low on falling edge 1. The data line is driven with 0 for the dummy slot at rising edge 2. The direction bit is sampled at rising edge 3, where 1 means read and 0 means write.
- R4: The 7 address bits appear most significant bit first, one at each of rising edges 4 to 10. The controller drives the line through all of them.
- R5: On a write, the 16 data bits appear most significant bit first at rising edges 11 to 26, with the controller driving. Select goes high on falling edge 26, and rising edge 27 occurs with select high so the device can commit the word.
- R6: On a read, `bus_sd_oe` goes low on falling edge 10 and stays low for the rest of the transfer. The device drives its bits from rising edge 12. The controller samples them on falling edges 12 to 27, most significant bit first, into `rdata`.
- R7: `done` is a single-cycle pulse, 54·HALF_DIV cycles after the start is accepted. For a read, `rdata` holds the new word from that cycle on.
- R8: A start pulse during an active transfer is ignored. The frame on the bus keeps the accepted direction, address and data, and no second done follows.
- R9: `bus_sel_n`, `bus_sd_o` and `bus_sd_oe` change only together with a falling `bus_sclk` edge, so they are stable at every rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, one cycle |
| rw | input | 1 | Direction: 1 read, 0 write |
| addr | input | 7 | Register address |
| wdata | input | 16 | Write word |
| rdata | output | 16 | Last read word |
| done | output | 1 | End-of-transfer pulse |
| bus_sclk | output | 1 | Serial clock |
| bus_sel_n | output | 1 | Active-low select |
| bus_sd_o | output | 1 | Data line output value |
| bus_sd_oe | output | 1 | Data line output enable |
| bus_sd_i | input | 1 | Data line input value |

## Verification
The done pulse is due exactly 54·HALF_DIV cycles after the cycle that accepts the start. The bench records the accepting cycle and compares the measured gap with that figure. `rdata` is compared in the same done cycle. A target model inside the bench watches the pins at falling system clock edges, half a cycle after each serial edge, and records what the device would capture at rising edges. It drives read bits half a system cycle after each rising edge, so they are settled well before the controller's falling-edge sample. The bench checks select, enable and the captured fields once per transfer, after done, and checks that done has dropped one cycle later.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic {
    TW_WRITE = 1'b0,
    TW_READ  = 1'b1
  } tw_dir_e;

  // bits driven ahead of the write word: dummy slot, direction, address
  function automatic int head_bits(input int aw);
    return 2 + aw;
  endfunction

  function automatic int frame_bits(input int aw, input int dw);
    return head_bits(aw) + dw;
  endfunction

endpackage

// File: rtl/tw_clkgen.sv
module tw_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic fall_tick
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] TERM = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick      = run && (div_q == TERM);
  assign fall_tick = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      sclk  <= 1'b0;
    end else if (div_q == TERM) begin
      div_q <= '0;
      sclk  <= ~sclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R1
  idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sclk);

endmodule

// File: rtl/tw_seq.sv
module tw_seq
  import tw_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fall_tick,
  output logic              run,
  output logic              sel_n,
  output logic              sd_o,
  output logic              sd_oe,
  output logic              sample_en,
  output logic              sample_last,
  output logic              done
);
  localparam int FRAME_W = frame_bits(ADDR_W, DATA_W);
  localparam int REL_I   = head_bits(ADDR_W) + 1;
  localparam int SMP_I   = head_bits(ADDR_W) + 3;
  localparam int UP_I    = FRAME_W + 1;
  localparam int END_I   = FRAME_W + 2;
  localparam int CNT_W   = $clog2(END_I + 1);

  localparam logic [CNT_W-1:0] F_FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] F_FRAME = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] F_REL   = CNT_W'(REL_I);
  localparam logic [CNT_W-1:0] F_SMP   = CNT_W'(SMP_I);
  localparam logic [CNT_W-1:0] F_UP    = CNT_W'(UP_I);
  localparam logic [CNT_W-1:0] F_END   = CNT_W'(END_I);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   nxt;
  logic [FRAME_W-1:0] tx_sr;
  tw_dir_e            dir_q;
  logic               busy;
  logic               is_rd;

  assign run   = busy;
  assign nxt   = cnt_q + 1'b1;
  assign is_rd = (dir_q == TW_READ);

  assign sample_en   = busy && fall_tick && is_rd && (nxt >= F_SMP) && (nxt <= F_END);
  assign sample_last = busy && fall_tick && is_rd && (nxt == F_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      dir_q <= TW_WRITE;
      tx_sr <= '0;
      sel_n <= 1'b1;
      sd_o  <= 1'b0;
      sd_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt_q <= '0;
          dir_q <= tw_dir_e'(rw);
          tx_sr <= {1'b0, rw, addr, wdata};
        end
      end else if (fall_tick) begin
        cnt_q <= nxt;
        if (nxt == F_FIRST) begin
          sel_n <= 1'b0;
          sd_oe <= 1'b1;
        end
        if ((nxt <= F_FRAME) && (!is_rd || (nxt < F_REL))) begin
          sd_o  <= tx_sr[FRAME_W-1];
          tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
        if (is_rd && (nxt == F_REL)) begin
          sd_oe <= 1'b0;
          sd_o  <= 1'b0;
        end
        if (!is_rd && (nxt == F_UP)) begin
          sel_n <= 1'b1;
          sd_oe <= 1'b0;
          sd_o  <= 1'b0;
        end
        if (nxt == F_END) begin
          sel_n <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  // R1
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sel_n && !sd_oe));

  // R9
  sel_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_n) |-> $past(fall_tick));

  // R9
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sd_o) || !$stable(sd_oe)) |-> $past(fall_tick));

  // R6
  read_released_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && (cnt_q >= F_REL)) |-> !sd_oe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !fall_tick) |=> ($stable(tx_sr) && $stable(dir_q)));

endmodule

// File: rtl/tw_rxshift.sv
module tw_rxshift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_en,
  input  logic              sample_last,
  input  logic              sd_i,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] sr_nxt;

  assign sr_nxt = {sr_q[DATA_W-2:0], sd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      rdata <= '0;
    end else if (sample_en) begin
      sr_q <= sr_nxt;
      if (sample_last) rdata <= sr_nxt;
    end
  end

  // R6
  last_is_sample_chk: assert property (@(posedge clk) disable iff (rst)
    sample_last |-> sample_en);

endmodule

// File: rtl/tw_master.sv
module tw_master #(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              bus_sclk,
  output logic              bus_sel_n,
  output logic              bus_sd_o,
  output logic              bus_sd_oe,
  input  logic              bus_sd_i
);
  logic run;
  logic fall_tick;
  logic sample_en;
  logic sample_last;

  tw_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sclk      (bus_sclk),
    .fall_tick (fall_tick)
  );

  tw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .rw          (rw),
    .addr        (addr),
    .wdata       (wdata),
    .fall_tick   (fall_tick),
    .run         (run),
    .sel_n       (bus_sel_n),
    .sd_o        (bus_sd_o),
    .sd_oe       (bus_sd_oe),
    .sample_en   (sample_en),
    .sample_last (sample_last),
    .done        (done)
  );

  tw_rxshift #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .sample_en   (sample_en),
    .sample_last (sample_last),
    .sd_i        (bus_sd_i),
    .rdata       (rdata)
  );

  // R1
  enable_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    bus_sd_oe |-> !bus_sel_n);

endmodule

// File: tb/test_tw_master.sv
`timescale 1ns/1ps
module test_tw_master;
  localparam int HALF   = 2;
  localparam int LAT    = 54 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rw = 1'b0;
  logic [6:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        done;
  logic        bus_sclk, bus_sel_n, bus_sd_o, bus_sd_oe;
  logic        bus_sd_i = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  tw_master #(.HALF_DIV(HALF)) i_tw_master (
    .clk(clk), .rst(rst), .start(start), .rw(rw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done(done), .bus_sclk(bus_sclk),
    .bus_sel_n(bus_sel_n), .bus_sd_o(bus_sd_o), .bus_sd_oe(bus_sd_oe),
    .bus_sd_i(bus_sd_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] seed_word(input int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // target model, observing half a system cycle after each edge
  logic [15:0] tgt_mem [128];
  logic [15:0] ref_mem [128];
  logic        sclk_seen = 1'b0;
  int          rise_n = 0;
  int          half_len = 0;
  logic        cap_rw;
  logic [6:0]  cap_addr;
  logic [15:0] cap_data;
  bit          bad_sel, bad_oe, bad_init, bad_commit, bad_half, committed;

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_sclk != sclk_seen) begin
        if (rise_n > 0 && half_len != HALF) bad_half = 1'b1;
        half_len = 1;
      end else if (bus_sclk) begin
        half_len++;
      end else begin
        half_len++;
      end
      if (bus_sclk && !sclk_seen) begin
        rise_n++;
        if (rise_n == 1 && !bus_sel_n) bad_sel = 1'b1;
        if (rise_n >= 2 && rise_n <= 26 && bus_sel_n) bad_sel = 1'b1;
        if (rise_n == 2 && (bus_sd_o !== 1'b0 || !bus_sd_oe)) bad_init = 1'b1;
        if (rise_n == 3) cap_rw = bus_sd_o;
        if (rise_n >= 3 && rise_n <= 10 && !bus_sd_oe) bad_oe = 1'b1;
        if (rise_n >= 4 && rise_n <= 10) cap_addr = {cap_addr[5:0], bus_sd_o};
        if (!cap_rw) begin
          if (rise_n >= 11 && rise_n <= 26) begin
            cap_data = {cap_data[14:0], bus_sd_o};
            if (!bus_sd_oe) bad_oe = 1'b1;
          end
          if (rise_n == 27) begin
            if (!bus_sel_n) bad_commit = 1'b1;
            else begin
              tgt_mem[cap_addr] = cap_data;
              committed = 1'b1;
            end
          end
        end else begin
          if (rise_n >= 11 && bus_sd_oe) bad_oe = 1'b1;
          if (rise_n >= 12 && rise_n <= 27) bus_sd_i = tgt_mem[cap_addr][27 - rise_n];
        end
      end
      sclk_seen = bus_sclk;
      if (done) begin
        rise_n = 0;
        bus_sd_i = 1'b0;
      end
    end
  end

  task automatic txn(input logic d, input logic [6:0] a, input logic [15:0] w,
                     input bit poke);
    int c0;
    int gap;
    bit got;
    bad_sel = 0; bad_oe = 0; bad_init = 0; bad_commit = 0; bad_half = 0;
    committed = 0; cap_data = '0; cap_addr = '0;
    @(negedge clk);
    start = 1'b1; rw = d; addr = a; wdata = w;
    @(negedge clk);
    start = 1'b0; c0 = cyc;
    rw = ~d; addr = ~a; wdata = ~w;
    got = 0;
    for (int i = 0; i < 1000; i++) begin
      if (poke && (cyc - c0) == 40) start = 1'b1;
      else start = 1'b0;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    start = 1'b0;
    gap = cyc - c0;
    check(got && gap == LAT, "R7 done latency", gap, LAT);
    check(bus_sel_n && !bus_sd_oe && !bus_sclk, "R1 released at end",
          {bus_sel_n, bus_sd_oe, bus_sclk}, 3'b100);
    check(!bad_half, "R2 half period", bad_half, 0);
    check(!bad_sel && !bad_init, "R3 select and dummy slot", {bad_sel, bad_init}, 0);
    check(cap_rw === d, "R3 direction bit", cap_rw, d);
    check(cap_addr === a, "R4 address", cap_addr, a);
    check(!bad_oe, d ? "R6 line released" : "R4 R5 line driven", bad_oe, 0);
    if (!d) begin
      check(committed && !bad_commit && cap_data === w, "R5 write word committed",
            cap_data, w);
      ref_mem[a] = w;
    end else begin
      check(rdata === ref_mem[a], "R6 read word", rdata, ref_mem[a]);
    end
    @(negedge clk);
    check(!done, "R7 single pulse", done, 0);
    if (poke) begin
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (done || bus_sclk || !bus_sel_n) begin
          check(0, "R8 no second transfer", {done, bus_sclk, bus_sel_n}, 3'b001);
          break;
        end
      end
      check(1, "R8 no second transfer", 0, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) begin
      tgt_mem[i] = seed_word(i);
      ref_mem[i] = seed_word(i);
    end
    repeat (4) @(negedge clk);
    check(bus_sel_n && !bus_sd_oe && !bus_sclk && !done, "R1 reset state",
          {bus_sel_n, bus_sd_oe, bus_sclk, done}, 4'b1000);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_sel_n && !bus_sd_oe && !bus_sclk && !done, "R1 idle after reset",
          {bus_sel_n, bus_sd_oe, bus_sclk, done}, 4'b1000);
    // directed corners
    txn(1'b0, 7'h00, 16'hFFFF, 0);
    txn(1'b0, 7'h7F, 16'h0000, 0);
    txn(1'b1, 7'h7F, 16'h1234, 0);
    txn(1'b1, 7'h00, 16'h0000, 0);
    txn(1'b1, 7'h2A, 16'h0000, 0);
    txn(1'b0, 7'h55, 16'hA5A5, 1);
    txn(1'b1, 7'h55, 16'h0000, 1);
    // random mix over a small address window so reads hit writes
    for (int n = 0; n < 30; n++) begin
      txn(1'($urandom % 2), 7'($urandom % 12) ^ 7'h40, 16'($urandom), n % 7 == 3);
      repeat (int'($urandom % 4)) @(negedge clk);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule